// File: doc/BRIEF.md
# Multimedia Interval Timer with Byte Register Interface

This block is a 20-bit up-counting interval timer that software controls through five byte-wide registers. The counter advances either on a slow timebase tick, made by dividing the core clock, or on every core clock when a test mode is selected. Software starts and stops it with a run bit. At start it either loads a preloaded value or carries on from the value it held when it last stopped.

When the count rolls over from its all-ones value to zero, a sticky interrupt flag is set and counting goes on without a pause. Software clears the flag by writing a one to its bit. The interrupt output is gated by an enable bit. A control bit holds the whole counting path in reset.

Reads return one byte per access. Reading the low count byte captures the upper count bits, so software that reads the low byte first gets a consistent 20-bit value from later reads of the upper bytes.

Top module: `mmt_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: The status register at offset 0 reads {4'b0, preload-select (bit 3), run (bit 2), flag (bit 1), enable (bit 0)}. The control register at offset 4 reads {6'b0, fast (bit 1), hold (bit 0)}. Both are written through the same offsets.
- R3: A write to offset 0 that sets run while the timer is stopped starts it. If bit 3 of that write is 1, the counter is loaded from the preload register on that edge. If bit 3 is 0, the counter keeps its current value.
- R4: Clearing run stops the counter, and it keeps its value.
- R5: In slow mode (fast = 0) a running counter advances by one once every DIV core clocks. The divider runs freely, independent of run.
- R6: In fast mode (fast = 1) a running counter advances on every core clock.
- R7: When a running counter steps from 0xFFFFF it wraps to 0 and sets the flag. Counting continues.
- R8: Writing 1 to status bit 1 clears the flag, and writing 0 leaves it unchanged. If a wrap happens in the same cycle as the clear, the flag is set.
- R9: `irq` is high exactly when both the flag and the enable bit are set.
- R10: While control bit 0 (hold) is set, the counter, the divider, run and the flag are held at zero, and writes to run and to the flag have no effect.
- R11: Offsets 1, 2 and 3 hold count bits 7:0, 15:8 and 19:16. Bits 7:4 of offset 3 read as zero. Writes to these offsets change only the preload register, never the counter.
- R12: A read of offset 1 captures count bits 19:8. Later reads of offsets 2 and 3 return the captured bits and not the live count.
- R13: `rdata` updates on the clock edge that samples `rd_en` and keeps its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions assume that `rst` is held for at least one edge before any access, and that `addr` is stable whenever a strobe is high. The flag-persistence property assumes that the only things that clear the flag are a write-one and hold. The bench drives all inputs on falling edges, one access at a time. Each read is issued as a separate strobe, so every sampled address is settled.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CNT0 = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CNT1 = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CNT2 = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd4;

  localparam int ST_EN   = 0;
  localparam int ST_FLAG = 1;
  localparam int ST_RUN  = 2;
  localparam int ST_PRE  = 3;

  localparam int CT_HOLD = 0;
  localparam int CT_FAST = 1;
endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
  parameter int DIV = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic fast,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || hold)        pcnt <= '0;
    else if (pcnt == LAST)  pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end

  assign tick = fast || (pcnt == LAST);

  // R5
  pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(pcnt) < DIV));
  // R10
  pcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (pcnt == '0));
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic             use_pre,
  input  logic [CNT_W-1:0] pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst || hold)          cnt <= '0;
    else if (start && use_pre) cnt <= pre;
    else if (run && tick)     cnt <= cnt + 1'b1;
  end

  assign wrap = !hold && run && tick && (cnt == '1);

  // R7
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && run && tick && (cnt == '1)) |=> (cnt == '0));
  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !run && !start) |=> $stable(cnt));
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));
endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int DIV   = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  localparam int EXT_W  = 3 * BYTE_W;
  localparam int SNAP_W = EXT_W - BYTE_W;

  logic en_q, flag_q, run_q, pre_sel_q, hold_q, fast_q;
  logic en_n, flag_n, run_n, pre_sel_n;
  logic [CNT_W-1:0]  pre_q, pre_n, cnt;
  logic [SNAP_W-1:0] snap_q;
  logic [EXT_W-1:0]  cnt_ext;
  logic [BYTE_W-1:0] rd_mux, rdata_q;
  logic irq_q, tick, wrap, wr_stat, start;

  assign wr_stat = wr_en && (addr == OFS_STAT);
  assign start   = wr_stat && wdata[ST_RUN] && !run_q && !hold_q;
  assign cnt_ext = EXT_W'(cnt);

  mmt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .hold(hold_q), .fast(fast_q), .tick(tick)
  );

  mmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(hold_q), .run(run_q), .tick(tick),
    .start(start), .use_pre(wdata[ST_PRE]), .pre(pre_q),
    .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    en_n      = wr_stat ? wdata[ST_EN]  : en_q;
    pre_sel_n = wr_stat ? wdata[ST_PRE] : pre_sel_q;
    if (hold_q)       run_n = 1'b0;
    else if (wr_stat) run_n = wdata[ST_RUN];
    else              run_n = run_q;
    if (hold_q)                          flag_n = 1'b0;
    else if (wrap)                       flag_n = 1'b1;
    else if (wr_stat && wdata[ST_FLAG])  flag_n = 1'b0;
    else                                 flag_n = flag_q;
  end

  always_comb begin
    pre_n = pre_q;
    for (int b = 0; b < CNT_W; b++) begin
      if (wr_en && (32'(addr) == 1 + b / BYTE_W))
        pre_n[b] = wdata[b % BYTE_W];
    end
  end

  always_comb begin
    case (addr)
      OFS_STAT: rd_mux = {4'b0, pre_sel_q, run_q, flag_q, en_q};
      OFS_CNT0: rd_mux = cnt_ext[BYTE_W-1:0];
      OFS_CNT1: rd_mux = snap_q[BYTE_W-1:0];
      OFS_CNT2: rd_mux = snap_q[SNAP_W-1:BYTE_W];
      OFS_CTRL: rd_mux = {6'b0, fast_q, hold_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; flag_q <= 1'b0; run_q <= 1'b0; pre_sel_q <= 1'b0;
      hold_q <= 1'b0; fast_q <= 1'b0; pre_q <= '0; snap_q <= '0;
      rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      en_q      <= en_n;
      flag_q    <= flag_n;
      run_q     <= run_n;
      pre_sel_q <= pre_sel_n;
      pre_q     <= pre_n;
      irq_q     <= flag_n && en_n;
      if (wr_en && (addr == OFS_CTRL)) begin
        hold_q <= wdata[CT_HOLD];
        fast_q <= wdata[CT_FAST];
      end
      if (rd_en) begin
        rdata_q <= rd_mux;
        if (addr == OFS_CNT0) snap_q <= cnt_ext[EXT_W-1:BYTE_W];
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !hold_q && !(wr_stat && wdata[ST_FLAG])) |=> flag_q);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && en_q));
  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && wdata[ST_PRE]) |=> (cnt == $past(pre_q)));
  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);
  // R13
  rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: tb/mmt_timer_test.sv
module mmt_timer_test;
  localparam int DIV  = 19;
  localparam int MAXC = (1 << 20) - 1;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mmt_timer #(.CNT_W(20), .DIV(DIV)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_pcnt, m_pre, m_snap;
  bit m_en, m_flag, m_run, m_psel, m_hold, m_fast, m_irq;
  logic [7:0] m_rdata;
  string m_tag = "R1";

  always @(posedge clk) begin
    bit tk, wrs, strt, wrp, nf, nr;
    int nc;
    if (rst) begin
      m_cnt = 0; m_pcnt = 0; m_pre = 0; m_snap = 0; m_en = 0; m_flag = 0;
      m_run = 0; m_psel = 0; m_hold = 0; m_fast = 0; m_irq = 0;
      m_rdata = 0; m_tag = "R1";
    end else begin
      tk   = m_fast || (m_pcnt == DIV - 1);
      wrp  = !m_hold && m_run && tk && (m_cnt == MAXC);
      wrs  = wr_en && (addr == 3'd0);
      strt = wrs && wdata[2] && !m_run && !m_hold;
      if (rd_en) begin
        case (addr)
          3'd0: begin m_rdata = {4'b0, m_psel, m_run, m_flag, m_en}; m_tag = "R2"; end
          3'd1: begin m_rdata = 8'(m_cnt & 255); m_snap = m_cnt >> 8; m_tag = "R11"; end
          3'd2: begin m_rdata = 8'(m_snap & 255); m_tag = "R12"; end
          3'd3: begin m_rdata = 8'((m_snap >> 8) & 255); m_tag = "R12"; end
          3'd4: begin m_rdata = {6'b0, m_fast, m_hold}; m_tag = "R2"; end
          default: begin m_rdata = 0; m_tag = "R13"; end
        endcase
      end
      if (m_hold) nc = 0;
      else if (strt && wdata[3]) nc = m_pre;
      else if (m_run && tk) nc = (m_cnt + 1) & MAXC;
      else nc = m_cnt;
      m_pcnt = m_hold ? 0 : ((m_pcnt == DIV - 1) ? 0 : m_pcnt + 1);
      if (m_hold) nf = 0;
      else if (wrp) nf = 1;
      else if (wrs && wdata[1]) nf = 0;
      else nf = m_flag;
      nr = m_hold ? 0 : (wrs ? wdata[2] : m_run);
      if (wrs) begin m_en = wdata[0]; m_psel = wdata[3]; end
      if (wr_en && addr >= 3'd1 && addr <= 3'd3) begin
        int sh;
        sh = 8 * (int'(addr) - 1);
        m_pre = ((m_pre & ~(255 << sh)) | (int'(wdata) << sh)) & MAXC;
      end
      if (wr_en && addr == 3'd4) begin m_hold = wdata[0]; m_fast = wdata[1]; end
      m_cnt = nc; m_flag = nf; m_run = nr;
      m_irq = m_flag && m_en;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 irq", int'(irq), int'(m_irq));
      check({m_tag, " R13 rdata"}, int'(rdata), int'(m_rdata));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, v0;
    idle(3);
    @(negedge clk); rst = 0;
    rd(3'd0, v); check("R1 status", v, 8'h00);
    rd(3'd4, v); check("R1 control", v, 8'h00);
    rd(3'd1, v); check("R1 count", v, 8'h00);
    check("R1 irq", int'(irq), 0);

    wr(3'd4, 8'h02);
    rd(3'd4, v); check("R2 control fast", v, 8'h02);

    wr(3'd1, 8'hF0); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    rd(3'd1, v); check("R11 preload write leaves count", v, 8'h00);
    rd(3'd3, v); check("R11 upper nibble zero", v, 8'h00);

    wr(3'd0, 8'h0D);
    idle(30);
    rd(3'd0, v); check("R7 R6 flag after fast wrap", v, 8'h0F);
    check("R9 irq with enable", int'(irq), 1);

    wr(3'd0, 8'h09);
    rd(3'd0, v); check("R8 write zero keeps flag", v, 8'h0B);
    rd(3'd1, v0); idle(5);
    rd(3'd1, v); check("R4 stopped count held", v, v0);

    wr(3'd0, 8'h0B);
    rd(3'd0, v); check("R8 write one clears flag", v, 8'h09);
    check("R9 irq low after clear", int'(irq), 0);

    rd(3'd1, v0);
    wr(3'd0, 8'h04);
    rd(3'd1, v); check("R3 resume from held value", v, (v0 + 1) & 255);
    idle(5);
    check("R13 rdata held while idle", int'(rdata), (v0 + 1) & 255);

    wr(3'd4, 8'h00);
    idle(DIV * 6);
    rd(3'd1, v);
    check("R5 slow mode tracks model", v, int'(m_rdata));

    wr(3'd4, 8'h01);
    rd(3'd1, v); check("R10 count zero in hold", v, 8'h00);
    rd(3'd0, v); check("R10 status in hold", v, 8'h00);
    wr(3'd0, 8'h06);
    rd(3'd0, v); check("R10 run write ignored", v, 8'h00);
    rd(3'd4, v); check("R2 control hold", v, 8'h01);
    wr(3'd4, 8'h02);

    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    wr(3'd0, 8'h0C);
    rd(3'd1, v); check("R12 low byte", v, 8'hFF);
    rd(3'd2, v); check("R12 snapshot middle byte", v, 8'hFF);
    rd(3'd3, v); check("R12 snapshot top byte", v, 8'h00);
    idle(40);

    wr(3'd1, 8'hF8); wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h0D);
    idle(6);
    wr(3'd0, 8'h0F);
    idle(4);
    rd(3'd0, v); check("R8 set wins over clear", v, int'(m_rdata));
    idle(10);
    finish_run();
  end
endmodule